// File: doc/BRIEF.md
# Privileged Trap Entry Unit

This block turns a single trap request into every state change that entering a trap handler requires. It takes the current privilege level, flags that say whether the trap is an interrupt, an exception or a non-maskable interrupt, a cause code, the address of the trapping instruction and a trap value. It then picks the privilege level that will handle the trap by walking the machine-level and supervisor-level delegation masks. For that level it produces write data for the cause, exception-PC and trap-value registers, a rewritten status word, the new privilege level and the address of the first handler instruction.

All results are registered. Every write strobe and the fetch redirect appear together as a one-cycle pulse in the cycle after the request strobe. A non-maskable interrupt always lands in machine mode, uses its own vector register, and also drives a strobe that clears the non-maskable-interrupt enable. Returning from a trap and the register-access instruction path are handled elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, and in every cycle not directly after a cycle with `trap_valid` high, `csr_we`, `redirect_valid` and `nmie_clr` are 0. In the cycle after `trap_valid` is high, `csr_we` and `redirect_valid` are both 1 for exactly that one cycle.
- R2: A non-maskable interrupt (`is_nmi`=1) always targets machine mode, whatever the delegation masks hold. The handler address comes from `nmivec` with bits 1:0 cleared and no vector offset. `nmie_clr` is 1 in the result cycle.
- R3: A non-NMI exception targets supervisor mode when the current privilege is not machine and bit `cause_code` of `medeleg` is set. Otherwise it targets machine mode.
- R4: A non-NMI exception that R3 sends to supervisor mode instead targets user mode when the current privilege is user and bit `cause_code` of `sedeleg` is set. A set `sedeleg` bit alone, without the `medeleg` bit, leaves the target at machine mode.
- R5: Interrupts (`is_irq`=1, `is_nmi`=0) follow the same two-step rule using `mideleg` and `sideleg`.
- R6: The status word is `status_in` with only the target level's bits changed. The status bit positions are: user enable 0, supervisor enable 1, machine enable 3, user previous-enable 4, supervisor previous-enable 5, machine previous-enable 7, supervisor previous-privilege 8, and machine previous-privilege bits 12:11. For the target level, the previous-enable bit takes the old enable bit and the enable bit becomes 0. For supervisor mode, bit 8 records bit 0 of the old privilege. For machine mode, bits 12:11 record the old privilege.
- R7: `cause_wdata` is `cause_code` zero-extended, with bit XLEN-1 set for interrupts and non-maskable interrupts. `csr_lvl` and `new_priv` both carry the target level, encoded 00 user, 01 supervisor, 11 machine.
- R8: `epc_wdata` equals the `trap_pc` of the request.
- R9: `tval_wdata` is 0 for an exception with cause code 2 (illegal instruction), and `trap_val` in every other case, including an interrupt with code 2.
- R10: For non-NMI traps, the handler address is the target level's vector register (`utvec`, `stvec` or `mtvec`) with bits 1:0 cleared. For interrupts only, when that register's bits 1:0 equal 01, 4 times `cause_code` is added. Mode values 00, 10 and 11 add nothing.
- R11: `nmie_clr` stays 0 for every trap that is not a non-maskable interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid | input | 1 | One-cycle trap request strobe |
| cur_priv | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| is_irq | input | 1 | Trap is an interrupt |
| is_nmi | input | 1 | Trap is a non-maskable interrupt |
| cause_code | input | $clog2(XLEN) | Cause code |
| trap_pc | input | XLEN | Address of the trapping instruction |
| trap_val | input | XLEN | Trap value (faulting address etc.) |
| status_in | input | XLEN | Current status word |
| medeleg | input | XLEN | Machine exception-delegation mask |
| sedeleg | input | XLEN | Supervisor exception-delegation mask |
| mideleg | input | XLEN | Machine interrupt-delegation mask |
| sideleg | input | XLEN | Supervisor interrupt-delegation mask |
| utvec | input | XLEN | User trap vector |
| stvec | input | XLEN | Supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector |
| nmivec | input | XLEN | Non-maskable-interrupt vector |
| csr_we | output | 1 | Write strobe for cause, epc, tval and status |
| csr_lvl | output | 2 | Level whose cause, epc and tval are written |
| cause_wdata | output | XLEN | Cause write data |
| epc_wdata | output | XLEN | Exception-PC write data |
| tval_wdata | output | XLEN | Trap-value write data |
| status_wdata | output | XLEN | New status word |
| nmie_clr | output | 1 | Clear the non-maskable-interrupt enable |
| new_priv | output | 2 | Privilege after entry |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | XLEN | Handler address |

## Verification
The bench targets the delegation corners. One case delegates from machine mode, which must stay in machine mode. Another sets only the supervisor mask bit from user mode, which must not skip straight to user. A third is an NMI whose cause bit is delegated, which must still reach machine mode through the NMI vector. A design that tests the two mask bits independently, or that forgets the current-privilege guard, sends these traps to the wrong level and writes the wrong status bits.

Other cases cover vector arithmetic. Vectored offsets must apply only to interrupts and only for mode 01: an exception through a vectored register, and an interrupt with mode 11, must both land on the base address. The illegal-instruction code must zero tval only when it comes from an exception, not from an interrupt with the same code. The previous-privilege fields are checked from user, supervisor and machine origins. A design that misplaces them would hand the return path a wrong mode.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    // status word bit positions (decoded by the return-from-trap logic)
    localparam int unsigned ST_UIE    = 0;
    localparam int unsigned ST_SIE    = 1;
    localparam int unsigned ST_MIE    = 3;
    localparam int unsigned ST_UPIE   = 4;
    localparam int unsigned ST_SPIE   = 5;
    localparam int unsigned ST_MPIE   = 7;
    localparam int unsigned ST_SPP    = 8;
    localparam int unsigned ST_MPP_LO = 11;

    localparam int unsigned CAUSE_ILLEGAL_INSN = 2;

    localparam logic [1:0] TVEC_MODE_VECTORED = 2'b01;

endpackage

// File: rtl/trap_target_sel.sv
module trap_target_sel
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned CODE_W = $clog2(XLEN)
) (
    input  logic [1:0]        cur_priv,
    input  logic              is_irq,
    input  logic              is_nmi,
    input  logic [CODE_W-1:0] cause_code,
    input  logic [XLEN-1:0]   medeleg,
    input  logic [XLEN-1:0]   sedeleg,
    input  logic [XLEN-1:0]   mideleg,
    input  logic [XLEN-1:0]   sideleg,
    output priv_e             target
);

    logic m_deleg_bit;
    logic s_deleg_bit;
    logic from_m;
    logic from_u;

    always_comb begin
        m_deleg_bit = is_irq ? mideleg[cause_code] : medeleg[cause_code];
        s_deleg_bit = is_irq ? sideleg[cause_code] : sedeleg[cause_code];
        from_m      = (cur_priv == PRIV_M);
        from_u      = (cur_priv == PRIV_U);

        target = PRIV_M;
        if (!is_nmi && !from_m && m_deleg_bit) begin
            target = PRIV_S;
            if (from_u && s_deleg_bit) begin
                target = PRIV_U;
            end
        end
    end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  priv_e           target,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] status_in,
    output logic [XLEN-1:0] status_out
);

    always_comb begin
        status_out = status_in;
        unique case (target)
            PRIV_U: begin
                status_out[ST_UPIE] = status_in[ST_UIE];
                status_out[ST_UIE]  = 1'b0;
            end
            PRIV_S: begin
                status_out[ST_SPP]  = cur_priv[0];
                status_out[ST_SPIE] = status_in[ST_SIE];
                status_out[ST_SIE]  = 1'b0;
            end
            default: begin
                status_out[ST_MPP_LO +: 2] = cur_priv;
                status_out[ST_MPIE]        = status_in[ST_MIE];
                status_out[ST_MIE]         = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned CODE_W = $clog2(XLEN)
) (
    input  priv_e             target,
    input  logic              is_irq,
    input  logic              is_nmi,
    input  logic [CODE_W-1:0] cause_code,
    input  logic [XLEN-1:0]   utvec,
    input  logic [XLEN-1:0]   stvec,
    input  logic [XLEN-1:0]   mtvec,
    input  logic [XLEN-1:0]   nmivec,
    output logic [XLEN-1:0]   handler_pc
);

    logic [XLEN-1:0] vec_sel;
    logic [XLEN-1:0] vec_base;
    logic [XLEN-1:0] vec_offset;
    logic            use_offset;

    always_comb begin
        if (is_nmi) begin
            vec_sel = nmivec;
        end else begin
            unique case (target)
                PRIV_U:  vec_sel = utvec;
                PRIV_S:  vec_sel = stvec;
                default: vec_sel = mtvec;
            endcase
        end

        vec_base   = {vec_sel[XLEN-1:2], 2'b00};
        use_offset = is_irq && !is_nmi && (vec_sel[1:0] == TVEC_MODE_VECTORED);
        vec_offset = use_offset ? (XLEN'(cause_code) << 2) : '0;
        handler_pc = vec_base + vec_offset;
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned CODE_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic [1:0]        cur_priv,
    input  logic              is_irq,
    input  logic              is_nmi,
    input  logic [CODE_W-1:0] cause_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_val,
    input  logic [XLEN-1:0]   status_in,
    input  logic [XLEN-1:0]   medeleg,
    input  logic [XLEN-1:0]   sedeleg,
    input  logic [XLEN-1:0]   mideleg,
    input  logic [XLEN-1:0]   sideleg,
    input  logic [XLEN-1:0]   utvec,
    input  logic [XLEN-1:0]   stvec,
    input  logic [XLEN-1:0]   mtvec,
    input  logic [XLEN-1:0]   nmivec,
    output logic              csr_we,
    output logic [1:0]        csr_lvl,
    output logic [XLEN-1:0]   cause_wdata,
    output logic [XLEN-1:0]   epc_wdata,
    output logic [XLEN-1:0]   tval_wdata,
    output logic [XLEN-1:0]   status_wdata,
    output logic              nmie_clr,
    output logic [1:0]        new_priv,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);

    localparam int unsigned IRQ_BIT = XLEN - 1;

    typedef struct packed {
        logic            csr_we;
        logic [1:0]      lvl;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] tval;
        logic [XLEN-1:0] status;
        logic            nmie_clr;
        logic [1:0]      priv;
        logic            redirect;
        logic [XLEN-1:0] pc;
    } entry_t;

    entry_t entry_d;
    entry_t entry_q;

    priv_e           target;
    logic [XLEN-1:0] status_new;
    logic [XLEN-1:0] handler_pc;
    logic            is_async;
    logic            is_illegal;

    trap_target_sel #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W)
    ) u_target (
        .cur_priv   (cur_priv),
        .is_irq     (is_irq),
        .is_nmi     (is_nmi),
        .cause_code (cause_code),
        .medeleg    (medeleg),
        .sedeleg    (sedeleg),
        .mideleg    (mideleg),
        .sideleg    (sideleg),
        .target     (target)
    );

    trap_status_upd #(
        .XLEN (XLEN)
    ) u_status (
        .target     (target),
        .cur_priv   (cur_priv),
        .status_in  (status_in),
        .status_out (status_new)
    );

    trap_vector_calc #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W)
    ) u_vector (
        .target     (target),
        .is_irq     (is_irq),
        .is_nmi     (is_nmi),
        .cause_code (cause_code),
        .utvec      (utvec),
        .stvec      (stvec),
        .mtvec      (mtvec),
        .nmivec     (nmivec),
        .handler_pc (handler_pc)
    );

    always_comb begin
        is_async   = is_irq || is_nmi;
        is_illegal = !is_async && (cause_code == CODE_W'(CAUSE_ILLEGAL_INSN));

        entry_d          = entry_q;
        entry_d.csr_we   = 1'b0;
        entry_d.redirect = 1'b0;
        entry_d.nmie_clr = 1'b0;

        if (trap_valid) begin
            entry_d.csr_we         = 1'b1;
            entry_d.lvl            = target;
            entry_d.cause          = XLEN'(cause_code);
            entry_d.cause[IRQ_BIT] = is_async;
            entry_d.epc            = trap_pc;
            entry_d.tval           = is_illegal ? '0 : trap_val;
            entry_d.status         = status_new;
            entry_d.nmie_clr       = is_nmi;
            entry_d.priv           = target;
            entry_d.redirect       = 1'b1;
            entry_d.pc             = handler_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else begin
            entry_q <= entry_d;
        end
    end

    assign csr_we         = entry_q.csr_we;
    assign csr_lvl        = entry_q.lvl;
    assign cause_wdata    = entry_q.cause;
    assign epc_wdata      = entry_q.epc;
    assign tval_wdata     = entry_q.tval;
    assign status_wdata   = entry_q.status;
    assign nmie_clr       = entry_q.nmie_clr;
    assign new_priv       = entry_q.priv;
    assign redirect_valid = entry_q.redirect;
    assign redirect_pc    = entry_q.pc;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned CODE_W = $clog2(XLEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_valid,
    input logic [1:0]        cur_priv,
    input logic              is_irq,
    input logic              is_nmi,
    input logic [XLEN-1:0]   trap_pc,
    input logic              csr_we,
    input logic [XLEN-1:0]   cause_wdata,
    input logic [XLEN-1:0]   epc_wdata,
    input logic              nmie_clr,
    input logic [1:0]        new_priv,
    input logic              redirect_valid,
    input logic [XLEN-1:0]   redirect_pc
);

    // R1
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (csr_we && redirect_valid));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> (!csr_we && !redirect_valid && !nmie_clr));

    // R2
    nmi_machine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && is_nmi) |=> (new_priv == 2'b11 && nmie_clr));

    // R3
    machine_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && cur_priv == 2'b11) |=> (new_priv == 2'b11));

    // R7
    sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !is_irq && !is_nmi) |=> !cause_wdata[XLEN-1]);

    // R7
    level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |-> (new_priv != 2'b10));

    // R8
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (epc_wdata == $past(trap_pc)));

    // R10
    pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc[1:0] == 2'b00));

    // R11
    nmie_only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !is_nmi) |=> !nmie_clr);

endmodule

bind trap_entry_unit trap_entry_chk #(
    .XLEN   (XLEN),
    .CODE_W (CODE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_valid     (trap_valid),
    .cur_priv       (cur_priv),
    .is_irq         (is_irq),
    .is_nmi         (is_nmi),
    .trap_pc        (trap_pc),
    .csr_we         (csr_we),
    .cause_wdata    (cause_wdata),
    .epc_wdata      (epc_wdata),
    .nmie_clr       (nmie_clr),
    .new_priv       (new_priv),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;

    localparam int unsigned XLEN   = 64;
    localparam int unsigned CODE_W = 6;
    localparam logic [63:0] IRQ    = 64'h8000_0000_0000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_valid;
    logic [1:0]        cur_priv;
    logic              is_irq, is_nmi;
    logic [CODE_W-1:0] cause_code;
    logic [XLEN-1:0]   trap_pc, trap_val, status_in;
    logic [XLEN-1:0]   medeleg, sedeleg, mideleg, sideleg;
    logic [XLEN-1:0]   utvec, stvec, mtvec, nmivec;
    logic              csr_we, nmie_clr, redirect_valid;
    logic [1:0]        csr_lvl, new_priv;
    logic [XLEN-1:0]   cause_wdata, epc_wdata, tval_wdata, status_wdata, redirect_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .cur_priv(cur_priv),
        .is_irq(is_irq), .is_nmi(is_nmi), .cause_code(cause_code),
        .trap_pc(trap_pc), .trap_val(trap_val), .status_in(status_in),
        .medeleg(medeleg), .sedeleg(sedeleg), .mideleg(mideleg), .sideleg(sideleg),
        .utvec(utvec), .stvec(stvec), .mtvec(mtvec), .nmivec(nmivec),
        .csr_we(csr_we), .csr_lvl(csr_lvl), .cause_wdata(cause_wdata),
        .epc_wdata(epc_wdata), .tval_wdata(tval_wdata), .status_wdata(status_wdata),
        .nmie_clr(nmie_clr), .new_priv(new_priv), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        trap_valid = 1'b0; cur_priv = 2'b11; is_irq = 1'b0; is_nmi = 1'b0;
        cause_code = '0; trap_pc = 64'h0; trap_val = 64'h0; status_in = 64'h0;
        medeleg = '0; sedeleg = '0; mideleg = '0; sideleg = '0;
        utvec = 64'h2000_0001; stvec = 64'h4000_0001;
        mtvec = 64'h8000_0001; nmivec = 64'h1000_0003;
    endtask

    // drive one request, sample the result cycle, then confirm the pulse ends
    task automatic fire(logic [1:0] prv, logic irq, logic nmi, int code,
                        logic [63:0] pc, logic [63:0] val, logic [63:0] st);
        @(negedge clk);
        cur_priv = prv; is_irq = irq; is_nmi = nmi; cause_code = CODE_W'(code);
        trap_pc = pc; trap_val = val; status_in = st; trap_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_req(string req);
        @(negedge clk);
        trap_valid = 1'b0;
        @(posedge clk);
        #1;
        check(req, "pulse ends csr_we", {63'd0, csr_we}, 64'd0);
        check(req, "pulse ends redirect", {63'd0, redirect_valid}, 64'd0);
    endtask

    task automatic expect_result(string req, logic [1:0] lvl, logic [63:0] cause,
                                 logic [63:0] epc, logic [63:0] tval, logic [63:0] st,
                                 logic nmic, logic [63:0] pc);
        check("R1", {req, " csr_we"}, {63'd0, csr_we}, 64'd1);
        check("R1", {req, " redirect"}, {63'd0, redirect_valid}, 64'd1);
        check(req, "level", {62'd0, csr_lvl}, {62'd0, lvl});
        check(req, "new_priv", {62'd0, new_priv}, {62'd0, lvl});
        check(req, "cause R7", cause_wdata, cause);
        check(req, "epc R8", epc_wdata, epc);
        check(req, "tval R9", tval_wdata, tval);
        check(req, "status R6", status_wdata, st);
        check(req, "nmie_clr R11", {63'd0, nmie_clr}, {63'd0, nmic});
        check(req, "handler R10", redirect_pc, pc);
    endtask

    task automatic t_reset();
        check("R1", "reset csr_we", {63'd0, csr_we}, 64'd0);
        check("R1", "reset redirect", {63'd0, redirect_valid}, 64'd0);
        check("R1", "reset nmie_clr", {63'd0, nmie_clr}, 64'd0);
    endtask

    task automatic t_exc_machine();
        // R3: S-mode misaligned load, not delegated, vectored mtvec ignored for exceptions
        fire(2'b01, 1'b0, 1'b0, 4, 64'h100, 64'h1003, 64'h8);
        expect_result("R3", 2'b11, 64'd4, 64'h100, 64'h1003, 64'h880, 1'b0, 64'h8000_0000);
        finish_req("R1");
    endtask

    task automatic t_exc_super();
        // R3: U-mode, medeleg bit 4 set -> S
        medeleg = 64'h10;
        fire(2'b00, 1'b0, 1'b0, 4, 64'h200, 64'h2001, 64'h2);
        expect_result("R3", 2'b01, 64'd4, 64'h200, 64'h2001, 64'h20, 1'b0, 64'h4000_0000);
        finish_req("R1");
        // R3: from machine mode the delegation bit is ignored
        fire(2'b11, 1'b0, 1'b0, 4, 64'h300, 64'h3001, 64'h0);
        expect_result("R3", 2'b11, 64'd4, 64'h300, 64'h3001, 64'h1800, 1'b0, 64'h8000_0000);
        finish_req("R1");
        medeleg = '0;
    endtask

    task automatic t_exc_user();
        // R4: both masks set from U -> U
        medeleg = 64'h2000; sedeleg = 64'h2000;
        fire(2'b00, 1'b0, 1'b0, 13, 64'h400, 64'h4444, 64'h1);
        expect_result("R4", 2'b00, 64'd13, 64'h400, 64'h4444, 64'h10, 1'b0, 64'h2000_0000);
        finish_req("R1");
        // R4: sedeleg alone does not move the trap
        medeleg = '0;
        fire(2'b00, 1'b0, 1'b0, 13, 64'h404, 64'h5555, 64'h0);
        expect_result("R4", 2'b11, 64'd13, 64'h404, 64'h5555, 64'h0, 1'b0, 64'h8000_0000);
        finish_req("R1");
        sedeleg = '0;
    endtask

    task automatic t_illegal();
        // R9: illegal instruction exception zeroes tval
        fire(2'b00, 1'b0, 1'b0, 2, 64'h500, 64'hdead_beef, 64'h1);
        expect_result("R9", 2'b11, 64'd2, 64'h500, 64'h0, 64'h1, 1'b0, 64'h8000_0000);
        finish_req("R1");
        // R9: interrupt with code 2 keeps trap_val; mode 00 gives base
        mtvec = 64'h8000_0000;
        fire(2'b11, 1'b1, 1'b0, 2, 64'h504, 64'hcafe, 64'h8);
        expect_result("R9", 2'b11, IRQ | 64'd2, 64'h504, 64'hcafe, 64'h1880, 1'b0, 64'h8000_0000);
        finish_req("R1");
        mtvec = 64'h8000_0001;
    endtask

    task automatic t_irq_vector();
        // R10: vectored interrupt adds 4*code
        fire(2'b11, 1'b1, 1'b0, 7, 64'h600, 64'h0, 64'h0);
        expect_result("R10", 2'b11, IRQ | 64'd7, 64'h600, 64'h0, 64'h1800, 1'b0, 64'h8000_001C);
        finish_req("R1");
        // R10: mode 11 is not vectored
        mtvec = 64'h8000_0003;
        fire(2'b11, 1'b1, 1'b0, 7, 64'h604, 64'h0, 64'h0);
        expect_result("R10", 2'b11, IRQ | 64'd7, 64'h604, 64'h0, 64'h1800, 1'b0, 64'h8000_0000);
        finish_req("R1");
        mtvec = 64'h8000_0001;
    endtask

    task automatic t_irq_deleg();
        // R5: S-mode interrupt delegated by mideleg, spp records S
        mideleg = 64'h20;
        fire(2'b01, 1'b1, 1'b0, 5, 64'h700, 64'h0, 64'h2);
        expect_result("R5", 2'b01, IRQ | 64'd5, 64'h700, 64'h0, 64'h120, 1'b0, 64'h4000_0014);
        finish_req("R1");
        // R5: U-mode interrupt through both masks
        mideleg = 64'h100; sideleg = 64'h100;
        fire(2'b00, 1'b1, 1'b0, 8, 64'h704, 64'h0, 64'h1);
        expect_result("R5", 2'b00, IRQ | 64'd8, 64'h704, 64'h0, 64'h10, 1'b0, 64'h2000_0020);
        finish_req("R1");
        mideleg = '0; sideleg = '0;
    endtask

    task automatic t_nmi();
        // R2: NMI ignores delegation, uses nmivec, clears NMI enable
        mideleg = 64'h8; medeleg = 64'h8;
        fire(2'b01, 1'b1, 1'b1, 3, 64'h800, 64'h77, 64'h2);
        expect_result("R2", 2'b11, IRQ | 64'd3, 64'h800, 64'h77, 64'h802, 1'b1, 64'h1000_0000);
        finish_req("R2");
        check("R11", "nmie_clr after NMI", {63'd0, nmie_clr}, 64'd0);
        mideleg = '0; medeleg = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        t_exc_machine();
        t_exc_super();
        t_exc_user();
        t_illegal();
        t_irq_vector();
        t_irq_deleg();
        t_nmi();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule